// File: doc/BRIEF.md
# Significand Rounding Stage

This block rounds an internal floating-point significand to its kept width. The incoming significand carries two extra low-order bits below the kept field: bit 1 is the guard bit and bit 0 is the round bit. A separate sticky input stands for every bit that was shifted out further down. The block drops the two extra bits and decides from the sign and a 2-bit mode code whether to add one unit in the last kept place. It reports whether it added that unit and whether the value was inexact.

The increment ripples through the whole kept field. The top bit of the kept field is headroom reserved by the caller. A kept field of `01_11...1` that is rounded up becomes `10_00...0`, which is the value 2.0. The stage does not renormalise this result. The caller uses the round-up flag to fix the exponent. Exponent handling, packing into storage formats and exception trapping all belong to the consumer.

With `REGISTERED=1` (the default) the result goes through a two-state output stage with one cycle of latency.
- State `ST_EMPTY` holds no result. It moves to `ST_FULL` on *accept* when `in_valid` is high, and otherwise stays there (*idle*).
- State `ST_FULL` presents a result. It stays in `ST_FULL` on *stream* when `in_valid` is high, and returns to `ST_EMPTY` on *drain* when `in_valid` is low.

With `REGISTERED=0` the stage is purely combinational and `out_valid` follows `in_valid`.

Top module: `rnd_unit`

## Requirements
- R1: When guard, round and sticky are all zero, `out_sig` equals `in_sig` shifted right by two, and both `out_up` and `out_inexact` are 0.
- R2: When any of guard (`in_sig[1]`), round (`in_sig[0]`) or `in_sticky` is 1, `out_inexact` is 1 in every mode.
- R3: Mode 2'b00 (nearest, ties to even) increments only when guard is 1 and at least one of these is 1: round, sticky, or the kept LSB `in_sig[2]`.
- R4: Mode 2'b01 (toward zero) never increments.
- R5: Mode 2'b10 (toward minus infinity) increments only when the result is inexact and `in_sign` is 1.
- R6: Mode 2'b11 (toward plus infinity) increments only when the result is inexact and `in_sign` is 0.
- R7: `out_sig` = (`in_sig` >> 2) + increment, modulo 2^(SIG_W-2), with the carry rippling through every kept bit. A kept field of `01_1..1` that is rounded up gives `10_0..0`, with no renormalisation.
- R8: `out_up` is 1 exactly when the increment was applied.
- R9: `out_valid` is `in_valid` delayed by one clock. While `in_valid` is low, `out_sig`, `out_up` and `out_inexact` keep their last values.
- R10: While `rst_n` is low, `out_valid`, `out_sig`, `out_up` and `out_inexact` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input operand is present |
| in_sign | input | 1 | Sign of the value: 1 means negative |
| in_sig | input | SIG_W | Significand; bit 1 is guard, bit 0 is round |
| in_sticky | input | 1 | OR of all bits discarded below the round bit |
| in_mode | input | 2 | 00 nearest, 01 toward zero, 10 toward minus infinity, 11 toward plus infinity |
| out_valid | output | 1 | Result is present |
| out_sig | output | SIG_W-2 | Rounded kept significand |
| out_up | output | 1 | An increment was applied |
| out_inexact | output | 1 | Guard, round or sticky was nonzero |

## Verification
The bench targets exact ties at both parities of the kept LSB. A design that rounds ties away from zero would give a wrong result on every even tie. It also drives a case where the sticky bit alone breaks a tie; a design that ignores sticky would round that case down. Both signs are driven in every directed mode, because swapping the two directed modes only shows up when the sign is varied. The full-width carry into the headroom bit and the hold of the outputs while `in_valid` is low are also checked; a short increment chain or an output stage that loads without a valid input would each fail there.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

    // Rounding-direction codes; the encoding is visible at the in_mode port.
    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_TO_ZERO = 2'b01,
        RM_TO_NEG  = 2'b10,
        RM_TO_POS  = 2'b11
    } rnd_mode_e;

    // Output stage occupancy.
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_st_e;

endpackage

// File: rtl/rnd_decide.sv
module rnd_decide
    import rnd_pkg::*;
(
    input  logic      sign,
    input  logic      guard,
    input  logic      rbit,
    input  logic      sticky,
    input  logic      lsb,
    input  rnd_mode_e mode,
    output logic      bump,
    output logic      inexact
);

    logic lost;

    always_comb begin
        lost    = guard | rbit | sticky;
        inexact = lost;
        bump    = 1'b0;
        unique case (mode)
            RM_NEAREST: bump = guard & (rbit | sticky | lsb);
            RM_TO_ZERO: bump = 1'b0;
            RM_TO_NEG:  bump = lost & sign;
            RM_TO_POS:  bump = lost & ~sign;
            default:    bump = guard & (rbit | sticky | lsb);
        endcase
    end

endmodule

// File: rtl/rnd_incr.sv
module rnd_incr #(
    parameter int W = 26
) (
    input  logic [W-1:0] a,
    input  logic         inc,
    output logic [W-1:0] sum
);

    logic [W-1:0] carry;

    assign carry[0] = inc;

    // Ripple half-adder chain; the carry out of the top bit is dropped.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i] = a[i] ^ carry[i];
        if (i < W - 1) begin : g_cy
            assign carry[i+1] = a[i] & carry[i];
        end
    end

endmodule

// File: rtl/rnd_core.sv
module rnd_core
    import rnd_pkg::*;
#(
    parameter int SIG_W = 28,
    localparam int KEEP_W = SIG_W - 2
) (
    input  logic              sign,
    input  logic [SIG_W-1:0]  sig,
    input  logic              sticky,
    input  rnd_mode_e         mode,
    output logic [KEEP_W-1:0] kept,
    output logic              up,
    output logic              inexact
);

    logic [KEEP_W-1:0] trunc;

    assign trunc = sig[SIG_W-1:2];

    rnd_decide u_dec (
        .sign    (sign),
        .guard   (sig[1]),
        .rbit    (sig[0]),
        .sticky  (sticky),
        .lsb     (sig[2]),
        .mode    (mode),
        .bump    (up),
        .inexact (inexact)
    );

    rnd_incr #(.W(KEEP_W)) u_inc (
        .a   (trunc),
        .inc (up),
        .sum (kept)
    );

endmodule

// File: rtl/rnd_unit.sv
module rnd_unit
    import rnd_pkg::*;
#(
    parameter int SIG_W      = 28,
    parameter bit REGISTERED = 1'b1,
    localparam int KEEP_W    = SIG_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sign,
    input  logic [SIG_W-1:0]  in_sig,
    input  logic              in_sticky,
    input  logic [1:0]        in_mode,
    output logic              out_valid,
    output logic [KEEP_W-1:0] out_sig,
    output logic              out_up,
    output logic              out_inexact
);

    logic [KEEP_W-1:0] c_sig;
    logic              c_up;
    logic              c_inexact;

    rnd_core #(.SIG_W(SIG_W)) u_core (
        .sign    (in_sign),
        .sig     (in_sig),
        .sticky  (in_sticky),
        .mode    (rnd_mode_e'(in_mode)),
        .kept    (c_sig),
        .up      (c_up),
        .inexact (c_inexact)
    );

    if (REGISTERED) begin : g_reg
        stage_st_e         st_q, st_d;
        logic [KEEP_W-1:0] sig_q;
        logic              up_q;
        logic              inx_q;

        // Next-state: accept / stream / drain / idle.
        always_comb begin
            st_d = st_q;
            unique case (st_q)
                ST_EMPTY: st_d = in_valid ? ST_FULL : ST_EMPTY;
                ST_FULL:  st_d = in_valid ? ST_FULL : ST_EMPTY;
                default:  st_d = ST_EMPTY;
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q <= ST_EMPTY;
            end else begin
                st_q <= st_d;
            end
        end

        // Result register loads only with a valid operand.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sig_q <= '0;
                up_q  <= 1'b0;
                inx_q <= 1'b0;
            end else if (in_valid) begin
                sig_q <= c_sig;
                up_q  <= c_up;
                inx_q <= c_inexact;
            end
        end

        assign out_valid   = (st_q == ST_FULL);
        assign out_sig     = sig_q;
        assign out_up      = up_q;
        assign out_inexact = inx_q;

        AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);  // R9
        AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);  // R9
        AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> ($stable(out_sig) && $stable(out_up) && $stable(out_inexact)));  // R9
        AST_EXACT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_sig[1:0] == 2'b00 && !in_sticky)
            |=> (!out_inexact && !out_up && out_sig == $past(in_sig[SIG_W-1:2])));  // R1
        AST_LOSS_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && (in_sig[1:0] != 2'b00 || in_sticky)) |=> out_inexact);  // R2
        AST_RTZ_NO_BUMP: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_mode == 2'b01) |=> !out_up);  // R4
        AST_NEG_DIR_POS: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_mode == 2'b10 && !in_sign) |=> !out_up);  // R5
        AST_POS_DIR_NEG: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_mode == 2'b11 && in_sign) |=> !out_up);  // R6
        AST_NEAR_NO_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_mode == 2'b00 && !in_sig[1]) |=> !out_up);  // R3
    end else begin : g_comb
        assign out_valid   = in_valid;
        assign out_sig     = c_sig;
        assign out_up      = c_up;
        assign out_inexact = c_inexact;
    end

endmodule

// File: tb/sim_rnd_unit.sv
`timescale 1ns/1ps
module sim_rnd_unit;

    localparam int SIG_W  = 28;
    localparam int KEEP_W = SIG_W - 2;

    typedef struct packed {
        logic              v;
        logic [KEEP_W-1:0] sig;
        logic              up;
        logic              inx;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_sign = 1'b0;
    logic [SIG_W-1:0]  in_sig = '0;
    logic              in_sticky = 1'b0;
    logic [1:0]        in_mode = 2'b00;
    logic              out_valid;
    logic [KEEP_W-1:0] out_sig;
    logic              out_up;
    logic              out_inexact;

    int    n_checks = 0;
    int    n_errors = 0;
    exp_t  exp_q[$];
    string tag_q[$];
    exp_t  held = '0;

    always #10 clk = ~clk;

    rnd_unit #(.SIG_W(SIG_W), .REGISTERED(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
        .in_sig(in_sig), .in_sticky(in_sticky), .in_mode(in_mode),
        .out_valid(out_valid), .out_sig(out_sig), .out_up(out_up),
        .out_inexact(out_inexact)
    );

    // Behavioural reference: rounding decision written from the requirements.
    function automatic exp_t model(logic sg, logic [SIG_W-1:0] s, logic st, logic [1:0] md);
        exp_t e;
        bit g, r, lsb, lost, inc;
        g = s[1]; r = s[0]; lsb = s[2];
        lost = g || r || st;
        if (md == 2'b00)      inc = g && (r || st || lsb);  // R3
        else if (md == 2'b01) inc = 0;                      // R4
        else if (md == 2'b10) inc = lost && sg;             // R5
        else                  inc = lost && !sg;            // R6
        e.v   = 1'b1;
        e.sig = KEEP_W'((s >> 2) + (inc ? 1 : 0));          // R7
        e.up  = inc;                                        // R8
        e.inx = lost;                                       // R2
        return e;
    endfunction

    task automatic chk(string tag, string what, logic [KEEP_W-1:0] act, logic [KEEP_W-1:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    task automatic compare_now();
        exp_t  e;
        string t;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
        end else begin
            e = held; e.v = 1'b0; t = "R9";
        end
        if (!e.v) begin
            e.sig = held.sig; e.up = held.up; e.inx = held.inx;
            t = {t, "/R9"};
        end else begin
            held = e;
        end
        chk(t, "valid",   KEEP_W'(out_valid),   KEEP_W'(e.v));
        chk(t, "sig",     out_sig,              e.sig);
        chk(t, "up",      KEEP_W'(out_up),      KEEP_W'(e.up));
        chk(t, "inexact", KEEP_W'(out_inexact), KEEP_W'(e.inx));
    endtask

    task automatic cyc(string tag, bit v, bit sg, logic [SIG_W-1:0] s, bit st, logic [1:0] md);
        exp_t e;
        @(negedge clk);
        compare_now();
        in_valid = v; in_sign = sg; in_sig = s; in_sticky = st; in_mode = md;
        e = model(sg, s, st, md);
        e.v = v;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : stim
        logic [SIG_W-1:0] top1;
        top1 = {2'b01, {KEEP_W-2{1'b1}}, 2'b11};
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "valid", KEEP_W'(out_valid), '0);
        chk("R10", "sig", out_sig, '0);
        chk("R10", "up", KEEP_W'(out_up), '0);
        chk("R10", "inexact", KEEP_W'(out_inexact), '0);
        rst_n = 1'b1;

        // R1 exact, all modes
        for (int m = 0; m < 4; m++) cyc("R1", 1, m[0], SIG_W'(28'h5A5_5AC0 + m * 4), 0, 2'(m));
        // R3 ties: even stays, odd bumps; sticky breaks tie
        cyc("R3", 1, 0, 28'h000_0012, 0, 2'b00);
        cyc("R3", 1, 0, 28'h000_0016, 0, 2'b00);
        cyc("R3", 1, 1, 28'h000_0012, 1, 2'b00);
        cyc("R3", 1, 0, 28'h000_0013, 0, 2'b00);
        cyc("R3", 1, 0, 28'h000_0011, 1, 2'b00);
        // R2 sticky only, every mode and sign
        for (int m = 0; m < 8; m++) cyc("R2", 1, m[2], 28'h123_4560, 1, 2'(m));
        // R4 toward zero with all lost bits set
        cyc("R4", 1, 0, 28'h0FF_FFFF, 1, 2'b01);
        cyc("R4", 1, 1, 28'h0FF_FFFF, 1, 2'b01);
        // R5 / R6 directed by sign
        cyc("R5", 1, 1, 28'h000_1001, 0, 2'b10);
        cyc("R5", 1, 0, 28'h000_1001, 0, 2'b10);
        cyc("R6", 1, 0, 28'h000_1001, 0, 2'b11);
        cyc("R6", 1, 1, 28'h000_1001, 0, 2'b11);
        // R7 carry into headroom (2.0), then hold with idle cycles (R9)
        cyc("R7", 1, 0, top1, 0, 2'b00);
        cyc("R9", 0, 0, 28'h0, 0, 2'b00);
        cyc("R9", 0, 1, 28'h3, 1, 2'b11);
        cyc("R7", 1, 0, top1, 0, 2'b11);
        cyc("R7", 1, 0, {SIG_W{1'b1}}, 0, 2'b11);
        // R8 random streaming with gaps
        for (int i = 0; i < 3000; i++) begin
            logic [SIG_W-1:0] rs;
            rs = SIG_W'({$urandom, $urandom});
            if (($urandom % 5) == 0) rs[1:0] = 2'b10;
            cyc("R8", ($urandom % 4) != 0, 1'($urandom), rs, (($urandom % 3) == 0), 2'($urandom));
        end
        cyc("R9", 0, 0, 28'h0, 0, 2'b00);
        @(negedge clk);
        compare_now();
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule